// File: doc/BRIEF.md
# Multi-Channel Serial Interrupt Concentrator

This block folds the level interrupt requests of many serial channels into a single interrupt line. Channels are arranged in groups of sixteen. Each group has three word registers: a read-only view of the raw request levels, a blocking mask in which a set bit silences the matching channel, and a control word whose bit 20 enables the group's output. Each group's request is its enable ANDed with the OR of the pending bits that the mask does not block. A board-level enable bit then gates the OR of all group requests before it drives the final interrupt pin.

Software reads the pending word to find which channels want service. It clears mask bits to admit channels. It sets the group and board enables once setup is done. Reset blocks every channel and clears every enable, so no interrupt can reach the processor before software has configured the block. Register access uses a simple word bus: a write strobe with data, and read data that follows the address combinationally.

Top module: `irq_concentrator`

## Requirements
- R1: The pending word of group g (address g*0x1000 + 0x004) returns the raw request levels of that group's channels as sampled at the previous clock edge. Bit n belongs to channel g*16+n. The mask has no effect on this word.
- R2: After reset every mask bit reads 1, the group control word reads 0, the board word reads 0, and all interrupt outputs are low.
- R3: A mask bit at 1 (mask at g*0x1000 + 0x008, bit n for channel n) stops channel n from contributing to any interrupt output. A mask bit at 0 lets the channel through.
- R4: grp_irq_o[g] is registered. One clock after the state changes, it equals the group enable ANDed with the OR of (pending AND NOT mask).
- R5: The group enable is bit 20 of the control word at g*0x1000 + 0x100. While it is 0, grp_irq_o[g] is low.
- R6: The board enable is bit 0 of the word at address NUM_GROUPS*0x1000 (0x2000 by default). While it is 0, irq_o is low one clock later.
- R7: irq_o is registered. It equals the board enable ANDed with the OR of all group requests, with the same one-clock latency as grp_irq_o.
- R8: Writes to the pending word change nothing. The mask changes only on a bus write to that group's mask address.
- R9: Unused bits read as zero: mask bits 31..16, control bits other than 20, and board bits 31..1. Unmapped addresses read as zero.
- R10: A write to one group's mask or control word leaves the other group's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_req_i | input | NUM_GROUPS*CH_PER_GROUP | Level requests, channel g*16+n at bit g*16+n |
| bus_addr_i | input | ADDR_W | Byte address of the word access |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| grp_irq_o | output | NUM_GROUPS | Registered per-group request |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bound checker checks the following properties on every cycle:
- Pending tracks the request inputs with one clock of delay.
- Each group output is derived from the previous cycle's enable, pending and mask.
- The combined output follows the group outputs and the board enable.
- Both enables force their outputs low.
- The mask stays stable when no write occurs.
- Unused mask bits read as zero.

Only the bench scenarios can show the remaining behaviours:
- The reset values.
- The address decode: which word each offset reaches, isolation between groups, and zero reads at unmapped addresses.
- That a pending write is ignored.
- The full sweep of channel positions against mask and enable patterns.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BUS_W        = 32;
  localparam int WIN_SHIFT    = 12;
  localparam int CTRL_EN_BIT  = 20;
  localparam int BOARD_EN_BIT = 0;

  localparam logic [WIN_SHIFT-1:0] OFF_PEND = 12'h004;
  localparam logic [WIN_SHIFT-1:0] OFF_MASK = 12'h008;
  localparam logic [WIN_SHIFT-1:0] OFF_CTRL = 12'h100;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_MASK,
    SEL_CTRL
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [WIN_SHIFT-1:0] off);
    reg_sel_e s;
    unique case (off)
      OFF_PEND: s = SEL_PEND;
      OFF_MASK: s = SEL_MASK;
      OFF_CTRL: s = SEL_CTRL;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_group.sv
module irqc_group
  import irqc_pkg::*;
#(
  parameter int CH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CH-1:0]        req_i,
  input  logic                 win_hit_i,
  input  logic [WIN_SHIFT-1:0] off_i,
  input  logic                 wr_i,
  input  logic [BUS_W-1:0]     wdata_i,
  output logic [BUS_W-1:0]     rdata_o,
  output logic [CH-1:0]        pend_o,
  output logic [CH-1:0]        mask_o,
  output logic                 en_o,
  output logic                 req_o
);
  reg_sel_e      sel;
  logic          mask_we;
  logic          ctrl_we;
  logic [CH-1:0] pend_q, pend_d;
  logic [CH-1:0] mask_q, mask_d;
  logic          en_q, en_d;
  logic [CH-1:0] live;

  assign sel     = win_hit_i ? decode_off(off_i) : SEL_NONE;
  assign mask_we = wr_i && (sel == SEL_MASK);
  assign ctrl_we = wr_i && (sel == SEL_CTRL);

  // next-state
  always_comb begin
    pend_d = req_i;
    mask_d = mask_q;
    en_d   = en_q;
    if (mask_we) mask_d = wdata_i[CH-1:0];
    if (ctrl_we) en_d   = wdata_i[CTRL_EN_BIT];
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (mask_we) mask_q <= mask_d;
      if (ctrl_we) en_q   <= en_d;
    end
  end

  assign live  = pend_q & ~mask_q;
  assign req_o = en_q && (|live);

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_PEND: rdata_o[CH-1:0]     = pend_q;
      SEL_MASK: rdata_o[CH-1:0]     = mask_q;
      SEL_CTRL: rdata_o[CTRL_EN_BIT] = en_q;
      default:  rdata_o             = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS   = 2,
  parameter int CH_PER_GROUP = 16,
  parameter int ADDR_W       = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_GROUPS*CH_PER_GROUP-1:0] chan_req_i,
  input  logic [ADDR_W-1:0]                bus_addr_i,
  input  logic                             bus_wr_i,
  input  logic [BUS_W-1:0]                 bus_wdata_i,
  output logic [BUS_W-1:0]                 bus_rdata_o,
  output logic [NUM_GROUPS-1:0]            grp_irq_o,
  output logic                             irq_o
);
  localparam int TOTAL_CH  = NUM_GROUPS * CH_PER_GROUP;
  localparam int GRP_IDX_W = ADDR_W - WIN_SHIFT;
  localparam logic [ADDR_W-1:0] BOARD_ADDR = ADDR_W'(NUM_GROUPS) << WIN_SHIFT;

  logic                  rst_sync_n;
  logic [TOTAL_CH-1:0]   pend_all;
  logic [TOTAL_CH-1:0]   mask_all;
  logic [NUM_GROUPS-1:0] en_all;
  logic [NUM_GROUPS-1:0] grp_req;
  logic [BUS_W-1:0]      grp_rdata [NUM_GROUPS];
  logic                  board_sel;
  logic                  board_we;
  logic                  board_en_q, board_en_d;
  logic [NUM_GROUPS-1:0] grp_irq_q, grp_irq_d;
  logic                  irq_q, irq_d;

  irqc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic win_hit;
    assign win_hit = (bus_addr_i[ADDR_W-1:WIN_SHIFT] == GRP_IDX_W'(g));

    irqc_group #(.CH(CH_PER_GROUP)) u_group (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .req_i     (chan_req_i[g*CH_PER_GROUP +: CH_PER_GROUP]),
      .win_hit_i (win_hit),
      .off_i     (bus_addr_i[WIN_SHIFT-1:0]),
      .wr_i      (bus_wr_i),
      .wdata_i   (bus_wdata_i),
      .rdata_o   (grp_rdata[g]),
      .pend_o    (pend_all[g*CH_PER_GROUP +: CH_PER_GROUP]),
      .mask_o    (mask_all[g*CH_PER_GROUP +: CH_PER_GROUP]),
      .en_o      (en_all[g]),
      .req_o     (grp_req[g])
    );
  end

  assign board_sel = (bus_addr_i == BOARD_ADDR);
  assign board_we  = bus_wr_i && board_sel;

  // next-state
  always_comb begin
    board_en_d = board_en_q;
    if (board_we) board_en_d = bus_wdata_i[BOARD_EN_BIT];
    grp_irq_d = grp_req;
    irq_d     = board_en_q && (|grp_req);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      board_en_q <= 1'b0;
      grp_irq_q  <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (board_we) board_en_q <= board_en_d;
      grp_irq_q <= grp_irq_d;
      irq_q     <= irq_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      bus_rdata_o = bus_rdata_o | grp_rdata[g];
    end
    if (board_sel) bus_rdata_o[BOARD_EN_BIT] = board_en_q;
  end

  assign grp_irq_o = grp_irq_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/irq_concentrator_chk.sv
module irq_concentrator_chk
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS   = 2,
  parameter int CH_PER_GROUP = 16,
  parameter int ADDR_W       = 16
) (
  input logic                               clk_i,
  input logic                               rst_sync_n,
  input logic [NUM_GROUPS*CH_PER_GROUP-1:0] chan_req_i,
  input logic [NUM_GROUPS*CH_PER_GROUP-1:0] pend_all,
  input logic [NUM_GROUPS*CH_PER_GROUP-1:0] mask_all,
  input logic [NUM_GROUPS-1:0]              en_all,
  input logic                               board_en_q,
  input logic [ADDR_W-1:0]                  bus_addr_i,
  input logic                               bus_wr_i,
  input logic [BUS_W-1:0]                   bus_rdata_o,
  input logic [NUM_GROUPS-1:0]              grp_irq_o,
  input logic                               irq_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b0;
    else             armed_q <= 1'b1;
  end

  // R1
  pend_follows_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    pend_all == $past(chan_req_i));

  // R7
  irq_combine_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    irq_o == ($past(board_en_q) && (|grp_irq_o)));

  // R6
  board_gate_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    !board_en_q |=> !irq_o);

  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    !bus_wr_i |=> $stable(mask_all));

  // R9
  mask_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    (bus_addr_i[WIN_SHIFT-1:0] == OFF_MASK) |-> ((bus_rdata_o >> CH_PER_GROUP) == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    // R4
    grp_out_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      grp_irq_o[g] == $past(en_all[g] &&
        (|(pend_all[g*CH_PER_GROUP +: CH_PER_GROUP] & ~mask_all[g*CH_PER_GROUP +: CH_PER_GROUP]))));
    // R5
    grp_en_gate_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      !en_all[g] |=> !grp_irq_o[g]);
  end
endmodule

bind irq_concentrator irq_concentrator_chk #(
  .NUM_GROUPS   (NUM_GROUPS),
  .CH_PER_GROUP (CH_PER_GROUP),
  .ADDR_W       (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_sync_n  (rst_sync_n),
  .chan_req_i  (chan_req_i),
  .pend_all    (pend_all),
  .mask_all    (mask_all),
  .en_all      (en_all),
  .board_en_q  (board_en_q),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rdata_o (bus_rdata_o),
  .grp_irq_o   (grp_irq_o),
  .irq_o       (irq_o)
);

// File: tb/irq_concentrator_bench.sv
module irq_concentrator_bench;
  localparam int NG = 2;
  localparam int CH = 16;
  localparam logic [15:0] A_PEND  = 16'h0004;
  localparam logic [15:0] A_MASK  = 16'h0008;
  localparam logic [15:0] A_CTRL  = 16'h0100;
  localparam logic [15:0] A_BOARD = 16'h2000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NG*CH-1:0] req;
  logic [15:0]   addr;
  logic          wr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NG-1:0] grp_irq;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  logic [CH-1:0] m_mask [NG];
  bit            m_en   [NG];
  bit            m_board;

  always #2 clk = ~clk;

  irq_concentrator u_irq_concentrator (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .chan_req_i  (req),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .grp_irq_o   (grp_irq),
    .irq_o       (irq)
  );

  function automatic logic [15:0] gbase(input int g);
    return 16'(g) << 12;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_mask(input int g, input logic [CH-1:0] v);
    bus_write(gbase(g) | A_MASK, {16'h0, v});
    m_mask[g] = v;
  endtask

  task automatic set_en(input int g, input bit e);
    bus_write(gbase(g) | A_CTRL, 32'(e) << 20);
    m_en[g] = e;
  endtask

  task automatic set_board(input bit b);
    bus_write(A_BOARD, {31'h0, b});
    m_board = b;
  endtask

  function automatic bit exp_grp(input int g);
    return m_en[g] && (|(req[g*CH +: CH] & ~m_mask[g]));
  endfunction

  task automatic check_outputs(input string tag);
    bit any;
    repeat (2) @(negedge clk);
    any = 1'b0;
    for (int g = 0; g < NG; g++) begin
      chk(grp_irq[g] == exp_grp(g), {tag, " R4 grp_irq"}, 32'(grp_irq[g]), 32'(exp_grp(g)));
      any = any | exp_grp(g);
    end
    chk(irq == (m_board && any), {tag, " R7 irq"}, 32'(irq), 32'(m_board && any));
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [CH-1:0] pat;
    rst_n = 1'b0; req = '0; addr = '0; wr = 1'b0; wdata = '0;
    for (int g = 0; g < NG; g++) begin m_mask[g] = '1; m_en[g] = 1'b0; end
    m_board = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    for (int g = 0; g < NG; g++) begin
      bus_read(gbase(g) | A_MASK, d); chk(d == 32'h0000_FFFF, "R2 mask reset", d, 32'h0000_FFFF);
      bus_read(gbase(g) | A_CTRL, d); chk(d == 32'h0, "R2 ctrl reset", d, 32'h0);
    end
    bus_read(A_BOARD, d); chk(d == 32'h0, "R2 board reset", d, 32'h0);
    chk(irq == 1'b0, "R2 irq reset", 32'(irq), 32'h0);
    chk(grp_irq == '0, "R2 grp_irq reset", 32'(grp_irq), 32'h0);

    // R1 pending mirrors raw levels while masked; R3 masked gives no irq
    set_board(1'b1); set_en(0, 1'b1); set_en(1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      req = {16'(16'h3C5A * (k + 1) ^ 16'h8001), 16'(16'hA5C3 + k * 16'h1111)};
      @(negedge clk);
      for (int g = 0; g < NG; g++) begin
        bus_read(gbase(g) | A_PEND, d);
        chk(d == {16'h0, req[g*CH +: CH]}, "R1 pending", d, {16'h0, req[g*CH +: CH]});
      end
      check_outputs("R3 all masked");
    end

    // R8 pending write ignored
    pat = req[15:0];
    bus_write(A_PEND, 32'hFFFF_FFFF);
    bus_read(A_PEND, d); chk(d == {16'h0, pat}, "R8 pending write ignored", d, {16'h0, pat});
    bus_read(A_MASK, d); chk(d == 32'h0000_FFFF, "R8 mask untouched", d, 32'h0000_FFFF);

    // R9 unused bits and unmapped addresses
    bus_write(A_CTRL, 32'hFFFF_FFFF); m_en[0] = 1'b1;
    bus_read(A_CTRL, d); chk(d == 32'h0010_0000, "R9 ctrl bits", d, 32'h0010_0000);
    bus_write(A_MASK, 32'hFFFF_FFFF);
    bus_read(A_MASK, d); chk(d == 32'h0000_FFFF, "R9 mask bits", d, 32'h0000_FFFF);
    bus_write(A_BOARD, 32'hFFFF_FFFF); m_board = 1'b1;
    bus_read(A_BOARD, d); chk(d == 32'h1, "R9 board bits", d, 32'h1);
    bus_read(16'h000C, d); chk(d == 32'h0, "R9 unmapped 0x000C", d, 32'h0);
    bus_read(16'h3008, d); chk(d == 32'h0, "R9 unmapped 0x3008", d, 32'h0);
    bus_read(16'h1200, d); chk(d == 32'h0, "R9 unmapped 0x1200", d, 32'h0);

    // R10 isolation between groups
    set_mask(0, 16'h1234);
    bus_read(gbase(1) | A_MASK, d); chk(d == 32'h0000_FFFF, "R10 other mask", d, 32'h0000_FFFF);
    set_en(1, 1'b0);
    bus_read(gbase(0) | A_CTRL, d); chk(d == 32'h0010_0000, "R10 other ctrl", d, 32'h0010_0000);
    set_en(1, 1'b1);

    // R3 sweep of every channel against mask patterns
    for (int g = 0; g < NG; g++) begin
      set_mask(1 - g, '1);
      for (int c = 0; c < CH; c++) begin
        @(negedge clk);
        req = '0;
        req[g*CH + c] = 1'b1;
        set_mask(g, ~(16'h1 << c));
        check_outputs("R3 unmasked channel");
        set_mask(g, 16'h1 << c);
        check_outputs("R3 masked channel");
        set_mask(g, 16'h0);
        @(negedge clk);
        req = '0;
        check_outputs("R3 none pending");
      end
    end

    // R5 R6 enable combinations
    set_mask(0, 16'h00F0); set_mask(1, 16'hF000);
    for (int k = 0; k < 8; k++) begin
      set_en(0, k[0]); set_en(1, k[1]); set_board(k[2]);
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        req = {p[1] ? 16'h0100 : 16'h8000, p[0] ? 16'h0001 : 16'h0010};
        check_outputs("R5 R6 enables");
      end
    end

    // R4 R7 one-clock latency after pending
    set_board(1'b1); set_en(0, 1'b1); set_en(1, 1'b0); set_mask(0, 16'h0);
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);
    req = 32'h0000_0004;
    @(negedge clk);
    chk(irq == 1'b0, "R7 latency not yet", 32'(irq), 32'h0);
    @(negedge clk);
    chk(irq == 1'b1, "R7 latency asserted", 32'(irq), 32'h1);
    chk(grp_irq[0] == 1'b1, "R4 latency asserted", 32'(grp_irq[0]), 32'h1);

    summary();
    $finish;
  end
endmodule